// File: doc/BRIEF.md
# Isochronous Header Sync-Stamp Inserter

This block builds the second header quadlet of every outgoing isochronous audio/video packet. The quadlet combines four parts. A fixed two-bit marker sits on top. Below it are a 6-bit stream format value and a 24-bit format-dependent field. The low 16 bits of that field can be overridden.

With frame-sync stamping turned off, the 24-bit field is sent exactly as supplied. With stamping turned on, the block watches an asynchronous frame-sync input between packets. If a rising edge was seen since the previous packet, the low 16 bits carry a time stamp taken when that edge was detected. If no edge was seen, they carry the all-ones "no information" code.

The transmit engine pulses a packet-start strobe once per packet. The assembled quadlet appears on the next cycle with a one-cycle valid pulse, and it holds until the next packet.

Top module: `cip_syt_stamper`

## Requirements
- R1: After reset, and before the first packet-start strobe, `hdrQuad` is 0x00000000 and `hdrValid` is 0.
- R2: `hdrValid` is high for exactly the one cycle after a cycle with `pktStart` high. `hdrQuad` changes only in that cycle and holds its value until the next packet, even when the inputs change.
- R3: Bits 31:30 of every latched quadlet are 2'b10. Bits 29:24 equal `fmtVal` as sampled in the packet-start cycle.
- R4: With `syncEnable` low at packet start, bits 23:0 equal `fieldVal`, whatever happened on `frameSyncIn`.
- R5: With `syncEnable` high at packet start, bits 23:16 equal `fieldVal[23:16]`.
- R6: With `syncEnable` high and a rising edge detected since the previous packet, bits 15:0 equal {`cycleCountLow`, `cycleOffset`} as sampled on the third rising clock edge after `frameSyncIn` goes high. That delay is two synchronizer flops plus one edge-detect flop.
- R7: With `syncEnable` high and no rising edge detected since the previous packet, bits 15:0 are 0xFFFF.
- R8: When several rising edges arrive between two packets, the stamp comes from the first of them.
- R9: The edge-seen state is cleared by each packet-start strobe, after that packet's quadlet has been built. An edge detected in the same cycle as `pktStart` counts toward the following packet.
- R10: Stamping reacts to edges, not levels. A sync input held high across two packets stamps only the first of them, and the second gets 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fmtVal | input | 6 | Stream format value for bits 29:24 |
| fieldVal | input | 24 | Format-dependent field for bits 23:0 |
| syncEnable | input | 1 | Enables sync-stamp replacement of the low 16 bits |
| frameSyncIn | input | 1 | Asynchronous frame-sync input |
| cycleCountLow | input | 4 | Low 4 bits of the current bus cycle count |
| cycleOffset | input | 12 | Current cycle offset |
| pktStart | input | 1 | One-cycle strobe marking the start of a packet |
| hdrQuad | output | 32 | Assembled second header quadlet |
| hdrValid | output | 1 | One-cycle pulse when `hdrQuad` is updated |

## Verification
The embedded assertions check the packet-to-valid timing and the holding of the quadlet between packets on every cycle. They also check the fixed marker bits, the pass-through of the field when stamping is off, the all-ones code when no edge was seen, and the setting and clearing of the edge-seen flag. Only the bench scenarios can show the rest. This covers the exact clock edge at which the stamp is sampled after synchronization, and the rule that the first of several edges wins. It also covers an edge coinciding with a packet start moving to the next packet, and a long high level stamping just once.

// File: rtl/cip_syt_pkg.sv
package cip_syt_pkg;

  // Strobes passed from the sync/control module to the header datapath.
  typedef struct packed {
    logic latchHdr;      // build and register a new header quadlet
    logic captureStamp;  // sample the cycle time into the stamp register
    logic stampMode;     // low field bits come from the stamp logic
    logic stampValid;    // an edge was seen since the previous packet
  } hdrStrobes_t;

  localparam logic [1:0] CIP_MARKER = 2'b10;

endpackage

// File: rtl/syt_sync_ctrl.sv
module syt_sync_ctrl
  import cip_syt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameSyncIn,
  input  logic        syncEnable,
  input  logic        pktStart,
  output hdrStrobes_t strobes
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   syncPrev;
  logic                   riseDet;
  logic                   edgeSeen;

  always_ff @(posedge clk) begin
    if (!rstN) syncChain[0] <= 1'b0;
    else       syncChain[0] <= frameSyncIn;
  end

  generate
    for (genvar i = 1; i < SYNC_STAGES; i++) begin : gSync
      always_ff @(posedge clk) begin
        if (!rstN) syncChain[i] <= 1'b0;
        else       syncChain[i] <= syncChain[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) syncPrev <= 1'b0;
    else       syncPrev <= syncChain[LAST];
  end

  assign riseDet = syncChain[LAST] & ~syncPrev;

  // A packet start closes the current window. An edge in the same
  // cycle opens the next window.
  always_ff @(posedge clk) begin
    if (!rstN)         edgeSeen <= 1'b0;
    else if (pktStart) edgeSeen <= riseDet;
    else if (riseDet)  edgeSeen <= 1'b1;
  end

  always_comb begin
    strobes.latchHdr     = pktStart;
    strobes.captureStamp = riseDet & (~edgeSeen | pktStart);
    strobes.stampMode    = syncEnable;
    strobes.stampValid   = edgeSeen;
  end

  // R6: a detected edge always leaves the flag set
  assert_edge_sets_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    riseDet |=> edgeSeen);

  // R9: a packet without a coincident edge clears the flag
  assert_pkt_clears_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    (pktStart && !riseDet) |=> !edgeSeen);

  // R8: once set, the flag persists until a packet start
  assert_flag_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    (edgeSeen && !pktStart) |=> edgeSeen);

  // R10: the edge detector fires only on a 0-to-1 step of the synced input
  assert_rise_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    riseDet |=> !riseDet);

endmodule

// File: rtl/syt_hdr_datapath.sv
module syt_hdr_datapath
  import cip_syt_pkg::*;
#(
  parameter int FMT_W     = 6,
  parameter int FIELD_W   = 24,
  parameter int CNT_LOW_W = 4,
  parameter int OFFS_W    = 12
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  hdrStrobes_t                    strobes,
  input  logic [FMT_W-1:0]               fmtVal,
  input  logic [FIELD_W-1:0]             fieldVal,
  input  logic [CNT_LOW_W-1:0]           cycleCountLow,
  input  logic [OFFS_W-1:0]              cycleOffset,
  output logic [2+FMT_W+FIELD_W-1:0]     hdrQuad,
  output logic                           hdrValid
);

  localparam int STAMP_W = CNT_LOW_W + OFFS_W;
  localparam int KEEP_W  = FIELD_W - STAMP_W;
  localparam int QUAD_W  = 2 + FMT_W + FIELD_W;

  logic [STAMP_W-1:0] stampReg;
  logic [STAMP_W-1:0] lowField;
  logic [QUAD_W-1:0]  nextQuad;

  always_ff @(posedge clk) begin
    if (!rstN)                     stampReg <= '0;
    else if (strobes.captureStamp) stampReg <= {cycleCountLow, cycleOffset};
    else if (strobes.latchHdr)     stampReg <= '0;
  end

  always_comb begin
    if (!strobes.stampMode)       lowField = fieldVal[STAMP_W-1:0];
    else if (strobes.stampValid)  lowField = stampReg;
    else                          lowField = '1;
  end

  generate
    if (KEEP_W > 0) begin : gKeep
      assign nextQuad = {CIP_MARKER, fmtVal, fieldVal[FIELD_W-1:STAMP_W], lowField};
    end else begin : gNoKeep
      assign nextQuad = {CIP_MARKER, fmtVal, lowField};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hdrQuad  <= '0;
      hdrValid <= 1'b0;
    end else begin
      hdrValid <= strobes.latchHdr;
      if (strobes.latchHdr) hdrQuad <= nextQuad;
    end
  end

  // R2: a latch is followed by a valid pulse
  assert_valid_after_latch_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.latchHdr |=> hdrValid);

  // R2: no latch, no pulse, quadlet held
  assert_hold_between_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.latchHdr |=> (!hdrValid && $stable(hdrQuad)));

  // R3: fixed marker bits
  assert_marker_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.latchHdr |=> (hdrQuad[QUAD_W-1 -: 2] == CIP_MARKER));

  // R4: field passes unchanged when stamping is off
  assert_passthru_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.latchHdr && !strobes.stampMode) |=> (hdrQuad[FIELD_W-1:0] == $past(fieldVal)));

  // R7: no edge gives the all-ones code
  assert_noinfo_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.latchHdr && strobes.stampMode && !strobes.stampValid)
      |=> (hdrQuad[STAMP_W-1:0] == {STAMP_W{1'b1}}));

endmodule

// File: rtl/cip_syt_stamper.sv
module cip_syt_stamper
  import cip_syt_pkg::*;
#(
  parameter int FMT_W       = 6,
  parameter int FIELD_W     = 24,
  parameter int CNT_LOW_W   = 4,
  parameter int OFFS_W      = 12,
  parameter int SYNC_STAGES = 2,
  localparam int QUAD_W     = 2 + FMT_W + FIELD_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [FMT_W-1:0]     fmtVal,
  input  logic [FIELD_W-1:0]   fieldVal,
  input  logic                 syncEnable,
  input  logic                 frameSyncIn,
  input  logic [CNT_LOW_W-1:0] cycleCountLow,
  input  logic [OFFS_W-1:0]    cycleOffset,
  input  logic                 pktStart,
  output logic [QUAD_W-1:0]    hdrQuad,
  output logic                 hdrValid
);

  hdrStrobes_t strobes;

  syt_sync_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .frameSyncIn (frameSyncIn),
    .syncEnable  (syncEnable),
    .pktStart    (pktStart),
    .strobes     (strobes)
  );

  syt_hdr_datapath #(
    .FMT_W     (FMT_W),
    .FIELD_W   (FIELD_W),
    .CNT_LOW_W (CNT_LOW_W),
    .OFFS_W    (OFFS_W)
  ) uData (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .fmtVal        (fmtVal),
    .fieldVal      (fieldVal),
    .cycleCountLow (cycleCountLow),
    .cycleOffset   (cycleOffset),
    .hdrQuad       (hdrQuad),
    .hdrValid      (hdrValid)
  );

endmodule

// File: tb/tb_cip_syt_stamper.sv
`timescale 1ns/1ps
module tb_cip_syt_stamper;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  fmtVal = '0;
  logic [23:0] fieldVal = '0;
  logic        syncEnable = 1'b0;
  logic        frameSyncIn = 1'b0;
  logic [3:0]  cycleCountLow = '0;
  logic [11:0] cycleOffset = '0;
  logic        pktStart = 1'b0;
  logic [31:0] hdrQuad;
  logic        hdrValid;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  cip_syt_stamper dut (
    .clk(clk), .rstN(rstN), .fmtVal(fmtVal), .fieldVal(fieldVal),
    .syncEnable(syncEnable), .frameSyncIn(frameSyncIn),
    .cycleCountLow(cycleCountLow), .cycleOffset(cycleOffset),
    .pktStart(pktStart), .hdrQuad(hdrQuad), .hdrValid(hdrValid)
  );

  typedef struct packed {
    logic [5:0]  fmt;
    logic [23:0] field;
    logic        en;
    logic        doEdge;
    logic [3:0]  cc;
    logic [11:0] off;
    logic [31:0] expQuad;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{6'h20, 24'h123456, 1'b0, 1'b0, 4'h0, 12'h000, 32'hA0123456},
    '{6'h01, 24'hABCDEF, 1'b0, 1'b1, 4'h5, 12'h111, 32'h81ABCDEF},
    '{6'h3F, 24'h987654, 1'b1, 1'b0, 4'h0, 12'h000, 32'hBF98FFFF},
    '{6'h10, 24'h001234, 1'b1, 1'b1, 4'h7, 12'hBCD, 32'h90007BCD},
    '{6'h00, 24'hFFFFFF, 1'b1, 1'b1, 4'hF, 12'h000, 32'h80FFF000},
    '{6'h2A, 24'h5A0000, 1'b1, 1'b0, 4'h0, 12'h000, 32'hAA5AFFFF}
  };

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic syncPulse(input logic [3:0] cc, input logic [11:0] off);
    @(negedge clk);
    cycleCountLow = cc;
    cycleOffset   = off;
    frameSyncIn   = 1'b1;
    repeat (4) @(negedge clk);
    frameSyncIn = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // Returns at the negedge after the latching edge.
  task automatic sendPacket();
    @(negedge clk);
    pktStart = 1'b1;
    @(negedge clk);
    pktStart = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(hdrQuad == 32'h0, "R1 quad", hdrQuad, 32'h0);
    check(hdrValid == 1'b0, "R1 valid", {31'b0, hdrValid}, 32'h0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(hdrQuad == 32'h0 && !hdrValid, "R1 idle", hdrQuad, 32'h0);

    // Vector table
    for (int i = 0; i < 6; i++) begin
      fmtVal = VECS[i].fmt;
      fieldVal = VECS[i].field;
      syncEnable = VECS[i].en;
      if (VECS[i].doEdge) syncPulse(VECS[i].cc, VECS[i].off);
      sendPacket();
      check(hdrValid == 1'b1, "R2 valid", {31'b0, hdrValid}, 32'h1);
      check(hdrQuad[31:24] == VECS[i].expQuad[31:24], "R3 marker/format", hdrQuad, VECS[i].expQuad);
      if (!VECS[i].en)
        check(hdrQuad[23:0] == VECS[i].expQuad[23:0], "R4 passthrough", hdrQuad, VECS[i].expQuad);
      else begin
        check(hdrQuad[23:16] == VECS[i].expQuad[23:16], "R5 upper field", hdrQuad, VECS[i].expQuad);
        if (VECS[i].doEdge)
          check(hdrQuad[15:0] == VECS[i].expQuad[15:0], "R6 stamp", hdrQuad, VECS[i].expQuad);
        else
          check(hdrQuad[15:0] == VECS[i].expQuad[15:0], "R7 no-edge code", hdrQuad, VECS[i].expQuad);
      end
    end

    // R2: pulse lasts one cycle and quadlet holds while inputs move
    begin
      logic [31:0] held;
      held = hdrQuad;
      fieldVal = 24'h0F0F0F;
      fmtVal = 6'h15;
      @(negedge clk);
      check(hdrValid == 1'b0, "R2 pulse width", {31'b0, hdrValid}, 32'h0);
      repeat (3) @(negedge clk);
      check(hdrQuad == held, "R2 hold", hdrQuad, held);
    end

    // R8: first of two edges wins
    syncEnable = 1'b1;
    fmtVal = 6'h01;
    fieldVal = 24'h330000;
    syncPulse(4'h1, 12'h111);
    syncPulse(4'h2, 12'h222);
    sendPacket();
    check(hdrQuad == 32'h81331111, "R8 first edge", hdrQuad, 32'h81331111);

    // R10: level held high stamps once
    @(negedge clk);
    cycleCountLow = 4'h9;
    cycleOffset = 12'h999;
    frameSyncIn = 1'b1;
    repeat (5) @(negedge clk);
    sendPacket();
    check(hdrQuad[15:0] == 16'h9999, "R10 first packet", hdrQuad, 32'h81339999);
    sendPacket();
    check(hdrQuad[15:0] == 16'hFFFF, "R10 second packet", hdrQuad, 32'h8133FFFF);
    frameSyncIn = 1'b0;
    repeat (4) @(negedge clk);

    // R9: edge detected in the packet-start cycle goes to the next packet
    cycleCountLow = 4'h3;
    cycleOffset = 12'h456;
    frameSyncIn = 1'b1;          // before rising edge E1
    @(negedge clk);              // after E1
    @(negedge clk);              // after E2: edge detected during this cycle
    pktStart = 1'b1;             // latched at E3 together with the capture
    @(negedge clk);
    pktStart = 1'b0;
    check(hdrQuad[15:0] == 16'hFFFF, "R9 coincident packet", hdrQuad, 32'h8133FFFF);
    cycleCountLow = 4'hA;
    cycleOffset = 12'hAAA;
    frameSyncIn = 1'b0;
    repeat (4) @(negedge clk);
    sendPacket();
    check(hdrQuad[15:0] == 16'h3456, "R9 following packet", hdrQuad, 32'h81333456);
    sendPacket();
    check(hdrQuad[15:0] == 16'hFFFF, "R9 cleared after packet", hdrQuad, 32'h8133FFFF);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule